// File: doc/BRIEF.md
# Wake Pin Settle-and-Interrupt Controller

This controller watches an active-low wake request input of a radio control chip. While the chip reports that it is in one of its working modes, every change of the synchronized pin level starts a settle timer from zero. If the pin holds its level until the timer reaches its limit, the controller records the pin state in a request status bit and raises an interrupt line. Any further change before the limit discards the earlier change and starts the timer again.

While the settle timer is running, a clock-keep-alive flag is held high so that the surrounding logic keeps its clock running. The interrupt stays pending until software reads the status register or issues a delete-interrupt command. Either action is signalled to this block as a one-cycle strobe. When the chip is not in a working mode, pin changes are ignored. If the working mode ends while the timer is running, the count is abandoned.

The control path has two named states. `WDB_WAIT` means no settle is in progress. `WDB_SETTLE` means the timer is running. The transitions are:
- WAIT→SETTLE on a pin change while active.
- SETTLE→SETTLE (restart) on a pin change.
- SETTLE→WAIT (complete) when the timer expires.
- SETTLE→WAIT (abort) when the active flag drops.

Top module: `wake_debounce_irq`

## Requirements
- R1: After reset the request status bit, the interrupt and the keep-alive flag are all 0, and no settle is in progress. The pin is assumed idle high.
- R2: The raw pin passes through a two-stage synchronizer. A change counts as an event when the synchronized level differs from its previously sampled value, so counting begins on the third rising clock edge after the pin changes.
- R3: While `active_mode` is 0, pin changes start no settle, never raise the interrupt and leave the status bit unchanged.
- R4: A pin event during a settle restarts the count from zero, and no completion occurs for the earlier change.
- R5: After an event, if no further event occurs, the settle completes exactly `SETTLE_CYCLES` clock edges after the event edge. On completion the status bit becomes 1 if the synchronized pin is low and 0 if it is high, the interrupt is set, and the timer stops.
- R6: `clk_keep` is 1 exactly while a settle is in progress, and it drops on the completion edge.
- R7: A one-cycle `status_rd` strobe clears a pending interrupt on the next edge.
- R8: A one-cycle `irq_del_cmd` strobe clears a pending interrupt on the next edge.
- R9: When a clear strobe and a completion fall on the same edge, the interrupt remains set.
- R10: If `active_mode` is 0 at an edge during a settle, the settle is aborted. `clk_keep` falls, and no interrupt or status change follows.
- R11: An event on the edge where the count would have completed restarts the count instead of completing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req_n | input | 1 | Raw active-low wake request pin |
| active_mode | input | 1 | 1 while the chip is in a working mode |
| status_rd | input | 1 | One-cycle strobe: status register read |
| irq_del_cmd | input | 1 | One-cycle strobe: delete-interrupt command |
| pwr_req_status | output | 1 | Settled request status, 1 when the pin is low |
| irq | output | 1 | Pending interrupt |
| clk_keep | output | 1 | Clock keep-alive, high while settling |

## Verification
The assertions assume that the clear strobes, `active_mode` and reset are synchronous to `clk`. They also assume that a status change can only follow a cycle in which a settle was running. The stimulus changes the pin and all control inputs only on falling edges, and it holds each strobe for exactly one cycle. The sweep places the second pin change at every offset from one cycle up to beyond the settle limit. It therefore covers restart, the tie at the final count, and two separate completions, including a clear strobe landing on a completion edge.

// File: rtl/wdb_pkg.sv
package wdb_pkg;

    // Control path states of the settle controller
    typedef enum logic [0:0] {
        WDB_WAIT   = 1'b0,
        WDB_SETTLE = 1'b1
    } wdb_state_t;

    // Request bit derived from an active-low pin level
    function automatic logic wdb_req_from_level(input logic level);
        return ~level;
    endfunction

endpackage

// File: rtl/wdb_pin_sync.sv
module wdb_pin_sync #(
    parameter int   STAGES      = 2,
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic level,
    output logic changed
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RESET_LEVEL;
                    else        chain_q[0] <= pin_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= RESET_LEVEL;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RESET_LEVEL;
        else        prev_q <= chain_q[LAST];
    end

    assign level   = chain_q[LAST];
    assign changed = chain_q[LAST] ^ prev_q;

endmodule

// File: rtl/wdb_settle_timer.sv
module wdb_settle_timer #(
    parameter int CYCLES = 8195
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic advance,
    output logic expired
);
    localparam int            CW       = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (advance && (cnt_q != LAST_CNT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LAST_CNT);

endmodule

// File: rtl/wdb_ctrl.sv
module wdb_ctrl
    import wdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic changed,
    input  logic level,
    input  logic expired,
    input  logic rd_strobe,
    input  logic del_strobe,
    output logic restart,
    output logic advance,
    output logic req_status,
    output logic irq_out,
    output logic keep_alive
);
    wdb_state_t state_q, state_d;
    logic       complete;

    // Next-state decision
    always_comb begin
        state_d  = state_q;
        complete = 1'b0;
        unique case (state_q)
            WDB_WAIT: begin
                if (active && changed) state_d = WDB_SETTLE;
            end
            WDB_SETTLE: begin
                if (!active) begin
                    state_d = WDB_WAIT;          // abort
                end else if (changed) begin
                    state_d = WDB_SETTLE;        // restart
                end else if (expired) begin
                    state_d  = WDB_WAIT;         // complete
                    complete = 1'b1;
                end
            end
            default: state_d = WDB_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WDB_WAIT;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_status <= 1'b0;
            irq_out    <= 1'b0;
        end else begin
            if (complete) begin
                req_status <= wdb_req_from_level(level);
                irq_out    <= 1'b1;
            end else if (rd_strobe || del_strobe) begin
                irq_out    <= 1'b0;
            end
        end
    end

    assign restart    = active && changed;
    assign advance    = (state_q == WDB_SETTLE);
    assign keep_alive = (state_q == WDB_SETTLE);

endmodule

// File: rtl/wake_debounce_irq.sv
module wake_debounce_irq #(
    parameter int SETTLE_CYCLES = 8195,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_req_n,
    input  logic active_mode,
    input  logic status_rd,
    input  logic irq_del_cmd,
    output logic pwr_req_status,
    output logic irq,
    output logic clk_keep
);
    logic sync_level;
    logic sync_changed;
    logic tmr_restart;
    logic tmr_advance;
    logic tmr_expired;

    wdb_pin_sync #(
        .STAGES      (SYNC_STAGES),
        .RESET_LEVEL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (pwr_req_n),
        .level   (sync_level),
        .changed (sync_changed)
    );

    wdb_settle_timer #(
        .CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .advance (tmr_advance),
        .expired (tmr_expired)
    );

    wdb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active_mode),
        .changed    (sync_changed),
        .level      (sync_level),
        .expired    (tmr_expired),
        .rd_strobe  (status_rd),
        .del_strobe (irq_del_cmd),
        .restart    (tmr_restart),
        .advance    (tmr_advance),
        .req_status (pwr_req_status),
        .irq_out    (irq),
        .keep_alive (clk_keep)
    );

endmodule

// File: rtl/wdb_checker.sv
module wdb_checker (
    input logic clk,
    input logic rst_n,
    input logic active_mode,
    input logic status_rd,
    input logic irq_del_cmd,
    input logic pwr_req_status,
    input logic irq,
    input logic clk_keep
);
    // R10: an inactive mode at an edge leaves no settle running
    assert_abort_drops_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active_mode |=> !clk_keep);

    // R5 / R6: a new interrupt only follows a running settle
    assert_irq_after_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(clk_keep));

    // R5: the status bit only moves at the end of a running settle
    assert_status_after_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_req_status) |-> $past(clk_keep));

    // R7 / R8: a pending interrupt stays until a clear strobe
    assert_irq_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !status_rd && !irq_del_cmd) |=> irq);

    // R7 / R8: a clear with no settle running removes the interrupt
    assert_irq_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && (status_rd || irq_del_cmd) && !clk_keep) |=> !irq);

    // R6: keep-alive falls only on completion or abort
    assert_keep_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_keep) |-> ($rose(irq) || irq || !$past(active_mode)));

endmodule

bind wake_debounce_irq wdb_checker u_wdb_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .active_mode    (active_mode),
    .status_rd      (status_rd),
    .irq_del_cmd    (irq_del_cmd),
    .pwr_req_status (pwr_req_status),
    .irq            (irq),
    .clk_keep       (clk_keep)
);

// File: tb/wake_debounce_irq_bench.sv
module wake_debounce_irq_bench;
    localparam int N = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_req_n = 1'b1;
    logic active_mode = 1'b0;
    logic status_rd = 1'b0;
    logic irq_del_cmd = 1'b0;
    logic pwr_req_status, irq, clk_keep;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wake_debounce_irq #(.SETTLE_CYCLES(N), .SYNC_STAGES(2)) u_wake_debounce_irq (
        .clk(clk), .rst_n(rst_n), .pwr_req_n(pwr_req_n), .active_mode(active_mode),
        .status_rd(status_rd), .irq_del_cmd(irq_del_cmd),
        .pwr_req_status(pwr_req_status), .irq(irq), .clk_keep(clk_keep)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "status", pwr_req_status, 1'b0);
        chk("R1", "irq", irq, 1'b0);
        chk("R1", "keep", clk_keep, 1'b0);
        rst_n = 1'b1;
        idle(3);
        chk("R1", "irq after release", irq, 1'b0);

        // R3: inactive mode ignores pin changes
        pwr_req_n = 1'b0;
        for (int c = 1; c <= N + 6; c++) begin
            step();
            chk("R3", "keep", clk_keep, 1'b0);
            chk("R3", "irq", irq, 1'b0);
            chk("R3", "status", pwr_req_status, 1'b0);
        end
        pwr_req_n = 1'b1;
        idle(5);
        active_mode = 1'b1;
        idle(3);

        // R10: abort on loss of active mode
        pwr_req_n = 1'b0;
        for (int c = 1; c <= 5; c++) begin
            step();
            // R2: counting starts on the third edge
            chk("R2", "keep", clk_keep, (c >= 3));
        end
        active_mode = 1'b0;
        for (int c = 1; c <= N + 5; c++) begin
            step();
            chk("R10", "keep", clk_keep, 1'b0);
            chk("R10", "irq", irq, 1'b0);
            chk("R10", "status", pwr_req_status, 1'b0);
        end
        active_mode = 1'b1;
        idle(N + 5);
        chk("R3", "no late event irq", irq, 1'b0);

        // R5 / R8: release pin, completion, clear by command
        pwr_req_n = 1'b1;
        for (int c = 1; c <= N + 3; c++) begin
            step();
            chk("R5", "irq", irq, (c >= N + 3));
            chk("R6", "keep", clk_keep, (c >= 3 && c < N + 3));
        end
        chk("R5", "status high pin", pwr_req_status, 1'b0);
        irq_del_cmd = 1'b1;
        step();
        irq_del_cmd = 1'b0;
        chk("R8", "irq cleared", irq, 1'b0);
        idle(3);

        // R4 / R5 / R7 / R9 / R11: sweep of second-change offset
        for (int g = 1; g <= N + 3; g++) begin
            pwr_req_n = 1'b0;
            for (int c = 1; c <= g + N + 3; c++) begin
                logic e_irq, e_keep, e_stat;
                step();
                if (c == g) pwr_req_n = 1'b1;
                if (c == N + 3) begin
                    if (g % 2 == 1) irq_del_cmd = 1'b1;
                    else            status_rd = 1'b1;
                end else begin
                    irq_del_cmd = 1'b0;
                    status_rd   = 1'b0;
                end
                e_irq  = ((g > N) && (c == N + 3)) || (c >= g + N + 3);
                e_keep = (c >= 3 && c < N + 3) || (c >= g + 3 && c < g + N + 3);
                e_stat = (g > N) && (c >= N + 3) && (c < g + N + 3);
                if (g == N) chk("R11", "irq tie", irq, e_irq);
                else if (g < N) chk("R4", "irq", irq, e_irq);
                else if (c == N + 4) chk((g % 2 == 1) ? "R8" : "R7", "irq clear", irq, e_irq);
                else chk("R5", "irq", irq, e_irq);
                if (g == 1 && c == N + 4) chk("R9", "clear vs complete", irq, 1'b1);
                chk("R6", "keep", clk_keep, e_keep);
                chk("R5", "status", pwr_req_status, e_stat);
            end
            irq_del_cmd = 1'b0;
            status_rd   = 1'b1;
            step();
            status_rd = 1'b0;
            chk("R7", "final clear", irq, 1'b0);
            idle(3);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule